// File: doc/BRIEF.md
# Virtqueue Common Configuration Register File

This block is the register file behind the common configuration window of a paravirtualized PCI device. A host bus slave port presents an offset, an access size in bytes (1, 2, 4 or 8), a write flag and little-endian write data. The block decodes each request against a map that depends on the access size. Byte accesses reach the driver status and the configuration generation. Word accesses reach the interrupt vectors, the queue count, the queue selector and the per-queue fields. Dword accesses reach the feature pages and the ring address halves. Qword accesses reach whole ring addresses.

Per-queue state is banked, one bank for each of `NUM_QUEUES` queues, and the queue-select register picks the bank. The 64-bit device feature vector is read through 32-bit pages chosen by a select register. Driver feature writes are turned into an acknowledge strobe that carries the written bits already shifted into their page. The queue enables, the ring addresses and the driver status are also driven out as ports for the queue engine next to the block.

A read answers on the cycle after the request with `rsp_valid`. The acknowledge strobe and the two error flags are single-cycle pulses on that same cycle.

Top module: `vq_cfg_regs`

## Requirements
- R1: A read of size 1, 2, 4 or 8 raises `rsp_valid` for exactly one cycle, on the cycle after the request. Writes never raise `rsp_valid`.
- R2: A byte read at 0x14 returns the driver status, and a byte write at 0x14 stores all 8 bits, which also appear on `drv_status`. A byte read at 0x15 returns `cfg_gen`. A byte write at 0x15 changes nothing.
- R3: Word offsets 0x10 (interrupt vector for configuration changes) and 0x16 (queue select) read back what was last written to them. Word offset 0x12 reads as NUM_QUEUES.
- R4: For the selected queue, word offsets 0x18 (queue size) and 0x1A (queue vector) read back the written 16-bit value. A write to word offset 0x1C sets the enable only when the word equals exactly 1 and clears it for any other value. The enable reads as 1 or 0 and is mirrored on `q_enabled[q]`.
- R5: A word read at 0x1E (notify offset) returns the current queue-select value.
- R6: When queue select is NUM_QUEUES or more, per-queue reads return 0. Per-queue writes then change nothing and raise no flag.
- R7: A dword read at 0x04 returns bits [32*s+31:32*s] of `dev_features`, where s is the value at dword 0x00. It returns 0 when s is 2 or more. Dword offsets 0x00 and 0x08 read back the last written value.
- R8: A dword write at 0x0C while the driver feature select (dword 0x08) is below 2 pulses `feat_ack_valid` with `feat_ack_bits` = data << (32*select). With a select of 2 or more, the write pulses `feat_sel_err` instead and produces no strobe.
- R9: The descriptor, available and used ring addresses of the selected queue are based at 0x20, 0x28 and 0x30. A dword write at the base replaces bits [31:0], and a dword write at base+4 replaces bits [63:32]. A qword write at the base replaces all 64 bits.
- R10: Qword reads return 0. A request of any size other than 1, 2, 4 or 8 changes no state and gives no response or flag.
- R11: Reads of unmapped offsets return 0. A valid-size write to an unmapped or read-only offset (0x15, 0x12, 0x1E, 0x04 and the like) changes nothing and pulses `bad_access` for one cycle.
- R12: After reset all registers, queue fields and output strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFS_W | Byte offset in the window |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, little-endian, right-aligned |
| dev_features | input | 64 | Device feature vector |
| cfg_gen | input | 8 | Configuration generation value |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data, right-aligned |
| feat_ack_valid | output | 1 | Driver feature acknowledge strobe |
| feat_ack_bits | output | 64 | Acknowledged feature bits in place |
| feat_sel_err | output | 1 | Driver feature write with a page select out of range |
| bad_access | output | 1 | Write to an unmapped or read-only offset |
| drv_status | output | 8 | Driver status value |
| q_enabled | output | NUM_QUEUES | Per-queue enable |
| q_desc_addr | output | NUM_QUEUES*64 | Descriptor ring addresses, queue q at [64q+:64] |
| q_avail_addr | output | NUM_QUEUES*64 | Available ring addresses |
| q_used_addr | output | NUM_QUEUES*64 | Used ring addresses |

## Verification
The bench sweeps every queue select from 0 to one past the last queue. At each select it writes distinct size, vector, enable and ring patterns, then checks every bank through the bus and through the ring ports. A decoder that truncated the selector would alias the out-of-range select onto queue 0 and corrupt it. Enable writes of 0, 1, 2, 3 and 0x101 catch a design that keeps bit 0 or tests for a nonzero value. Feature pages 0 to 3 are swept on both select registers: a wrong shift, or a missing limit on the page, shows up as wrong read data or as a strobe where an error was due. Dword halves written in both orders, followed by a qword overwrite, catch writes that merge into the wrong half. Writes of valid and invalid sizes to read-only and unmapped offsets catch writes that leak into state or flags that are missing.

// File: rtl/vqcfg_pkg.sv
package vqcfg_pkg;
  typedef enum logic [4:0] {
    K_NONE, K_DSTAT, K_CGEN, K_MSIX, K_NQ, K_QSEL, K_QSIZE, K_QVEC,
    K_QEN, K_QNOFF, K_DFSEL, K_DFEAT, K_GFSEL, K_GFEAT,
    K_RING_LO, K_RING_HI, K_RING_Q
  } cfg_kind_e;

  localparam int unsigned RING_CNT = 3;
  localparam int unsigned ADDR_W   = 64;
endpackage

// File: rtl/vqcfg_decode.sv
module vqcfg_decode #(
  parameter int unsigned OFS_W = 8
) (
  input  logic [OFS_W-1:0]     offset,
  input  logic [3:0]           size,
  output vqcfg_pkg::cfg_kind_e kind,
  output logic [1:0]           ring_idx,
  output logic                 size_ok
);
  import vqcfg_pkg::*;

  always_comb begin
    kind     = K_NONE;
    ring_idx = 2'd0;
    size_ok  = (size == 4'd1) || (size == 4'd2) || (size == 4'd4) || (size == 4'd8);
    unique case (size)
      4'd1: begin
        if (offset == OFS_W'('h14)) kind = K_DSTAT;
        if (offset == OFS_W'('h15)) kind = K_CGEN;
      end
      4'd2: begin
        case (offset)
          OFS_W'('h10): kind = K_MSIX;
          OFS_W'('h12): kind = K_NQ;
          OFS_W'('h16): kind = K_QSEL;
          OFS_W'('h18): kind = K_QSIZE;
          OFS_W'('h1A): kind = K_QVEC;
          OFS_W'('h1C): kind = K_QEN;
          OFS_W'('h1E): kind = K_QNOFF;
          default:      kind = K_NONE;
        endcase
      end
      4'd4: begin
        case (offset)
          OFS_W'('h00): kind = K_DFSEL;
          OFS_W'('h04): kind = K_DFEAT;
          OFS_W'('h08): kind = K_GFSEL;
          OFS_W'('h0C): kind = K_GFEAT;
          OFS_W'('h20): begin kind = K_RING_LO; ring_idx = 2'd0; end
          OFS_W'('h24): begin kind = K_RING_HI; ring_idx = 2'd0; end
          OFS_W'('h28): begin kind = K_RING_LO; ring_idx = 2'd1; end
          OFS_W'('h2C): begin kind = K_RING_HI; ring_idx = 2'd1; end
          OFS_W'('h30): begin kind = K_RING_LO; ring_idx = 2'd2; end
          OFS_W'('h34): begin kind = K_RING_HI; ring_idx = 2'd2; end
          default:      kind = K_NONE;
        endcase
      end
      4'd8: begin
        case (offset)
          OFS_W'('h20): begin kind = K_RING_Q; ring_idx = 2'd0; end
          OFS_W'('h28): begin kind = K_RING_Q; ring_idx = 2'd1; end
          OFS_W'('h30): begin kind = K_RING_Q; ring_idx = 2'd2; end
          default:      kind = K_NONE;
        endcase
      end
      default: kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/vqcfg_queue_bank.sv
module vqcfg_queue_bank #(
  parameter int unsigned NUM_QUEUES = 4,
  parameter int unsigned QSEL_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  vqcfg_pkg::cfg_kind_e         kind,
  input  logic [1:0]                   ring_idx,
  input  logic [QSEL_W-1:0]            qsel,
  input  logic [63:0]                  wdata,
  output logic                         in_range,
  output logic [15:0]                  rd_size,
  output logic [15:0]                  rd_vec,
  output logic                         rd_en,
  output logic [NUM_QUEUES-1:0]        en_vec,
  output logic [NUM_QUEUES*64-1:0]     desc_flat,
  output logic [NUM_QUEUES*64-1:0]     avail_flat,
  output logic [NUM_QUEUES*64-1:0]     used_flat
);
  import vqcfg_pkg::*;

  localparam int unsigned AW = ADDR_W;

  logic [NUM_QUEUES*16-1:0] size_flat;
  logic [NUM_QUEUES*16-1:0] vec_flat;

  assign in_range = ({16'd0, qsel} < (QSEL_W + 16)'(NUM_QUEUES));

  for (genvar qi = 0; qi < NUM_QUEUES; qi++) begin : g_queue
    logic          hit;
    logic [15:0]   size_q, size_d, vec_q, vec_d;
    logic          en_q, en_d;
    logic [AW-1:0] ring_q [RING_CNT];
    logic [AW-1:0] ring_d [RING_CNT];

    assign hit = wr_en && (qsel == QSEL_W'(qi));

    always_comb begin
      size_d = size_q;
      vec_d  = vec_q;
      en_d   = en_q;
      if (hit) begin
        case (kind)
          K_QSIZE: size_d = wdata[15:0];
          K_QVEC:  vec_d  = wdata[15:0];
          K_QEN:   en_d   = (wdata[15:0] == 16'd1);
          default: ;
        endcase
      end
    end

    for (genvar ri = 0; ri < RING_CNT; ri++) begin : g_ring
      always_comb begin
        ring_d[ri] = ring_q[ri];
        if (hit && (ring_idx == 2'(ri))) begin
          case (kind)
            K_RING_LO: ring_d[ri] = {ring_q[ri][63:32], wdata[31:0]};
            K_RING_HI: ring_d[ri] = {wdata[31:0], ring_q[ri][31:0]};
            K_RING_Q:  ring_d[ri] = wdata;
            default:   ;
          endcase
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q[ri] <= '0;
        else        ring_q[ri] <= ring_d[ri];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        size_q <= '0;
        vec_q  <= '0;
        en_q   <= 1'b0;
      end else if (hit) begin
        size_q <= size_d;
        vec_q  <= vec_d;
        en_q   <= en_d;
      end
    end

    assign size_flat[qi*16 +: 16] = size_q;
    assign vec_flat[qi*16 +: 16]  = vec_q;
    assign en_vec[qi]             = en_q;
    assign desc_flat[qi*64 +: 64]  = ring_q[0];
    assign avail_flat[qi*64 +: 64] = ring_q[1];
    assign used_flat[qi*64 +: 64]  = ring_q[2];
  end

  always_comb begin
    rd_size = '0;
    rd_vec  = '0;
    rd_en   = 1'b0;
    for (int i = 0; i < NUM_QUEUES; i++) begin
      if (qsel == QSEL_W'(i)) begin
        rd_size = size_flat[i*16 +: 16];
        rd_vec  = vec_flat[i*16 +: 16];
        rd_en   = en_vec[i];
      end
    end
  end
endmodule

// File: rtl/vq_cfg_regs.sv
module vq_cfg_regs #(
  parameter int unsigned NUM_QUEUES = 4,
  parameter int unsigned OFS_W      = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [OFS_W-1:0]         req_offset,
  input  logic [3:0]               req_size,
  input  logic [63:0]              req_wdata,
  input  logic [63:0]              dev_features,
  input  logic [7:0]               cfg_gen,
  output logic                     rsp_valid,
  output logic [63:0]              rsp_rdata,
  output logic                     feat_ack_valid,
  output logic [63:0]              feat_ack_bits,
  output logic                     feat_sel_err,
  output logic                     bad_access,
  output logic [7:0]               drv_status,
  output logic [NUM_QUEUES-1:0]    q_enabled,
  output logic [NUM_QUEUES*64-1:0] q_desc_addr,
  output logic [NUM_QUEUES*64-1:0] q_avail_addr,
  output logic [NUM_QUEUES*64-1:0] q_used_addr
);
  import vqcfg_pkg::*;

  localparam int unsigned QSEL_W = 16;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  cfg_kind_e   kind;
  logic [1:0]  ring_idx;
  logic        size_ok;

  vqcfg_decode #(.OFS_W(OFS_W)) u_dec (
    .offset(req_offset), .size(req_size),
    .kind(kind), .ring_idx(ring_idx), .size_ok(size_ok)
  );

  logic wr, rd;
  assign wr = req_valid && req_write && size_ok;
  assign rd = req_valid && !req_write && size_ok;

  logic [7:0]        drv_q, drv_d;
  logic [15:0]       msix_q, msix_d;
  logic [QSEL_W-1:0] qsel_q, qsel_d;
  logic [31:0]       dfsel_q, dfsel_d, gfsel_q, gfsel_d;
  logic              rv_q, rv_d, ackv_q, ackv_d, err_q, err_d, bad_q, bad_d;
  logic [63:0]       rdat_q, rdat_d, ackb_q, ackb_d, rd_mux;

  logic        q_in_range, q_rd_en;
  logic [15:0] q_rd_size, q_rd_vec;

  vqcfg_queue_bank #(.NUM_QUEUES(NUM_QUEUES), .QSEL_W(QSEL_W)) u_bank (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr), .kind(kind), .ring_idx(ring_idx),
    .qsel(qsel_q), .wdata(req_wdata), .in_range(q_in_range),
    .rd_size(q_rd_size), .rd_vec(q_rd_vec), .rd_en(q_rd_en),
    .en_vec(q_enabled), .desc_flat(q_desc_addr), .avail_flat(q_avail_addr),
    .used_flat(q_used_addr)
  );

  // read data selection
  always_comb begin
    rd_mux = '0;
    case (kind)
      K_DSTAT: rd_mux = 64'(drv_q);
      K_CGEN:  rd_mux = 64'(cfg_gen);
      K_MSIX:  rd_mux = 64'(msix_q);
      K_NQ:    rd_mux = 64'(NUM_QUEUES);
      K_QSEL:  rd_mux = 64'(qsel_q);
      K_QSIZE: rd_mux = q_in_range ? 64'(q_rd_size) : 64'd0;
      K_QVEC:  rd_mux = q_in_range ? 64'(q_rd_vec) : 64'd0;
      K_QEN:   rd_mux = (q_in_range && q_rd_en) ? 64'd1 : 64'd0;
      K_QNOFF: rd_mux = 64'(qsel_q);
      K_DFSEL: rd_mux = 64'(dfsel_q);
      K_DFEAT: begin
        if (dfsel_q == 32'd0)      rd_mux = 64'(dev_features[31:0]);
        else if (dfsel_q == 32'd1) rd_mux = 64'(dev_features[63:32]);
      end
      K_GFSEL: rd_mux = 64'(gfsel_q);
      default: rd_mux = '0;
    endcase
  end

  // next state
  always_comb begin
    drv_d   = drv_q;
    msix_d  = msix_q;
    qsel_d  = qsel_q;
    dfsel_d = dfsel_q;
    gfsel_d = gfsel_q;
    ackv_d  = 1'b0;
    ackb_d  = '0;
    err_d   = 1'b0;
    bad_d   = 1'b0;
    rv_d    = rd;
    rdat_d  = rd ? rd_mux : '0;
    if (wr) begin
      case (kind)
        K_DSTAT: drv_d   = req_wdata[7:0];
        K_MSIX:  msix_d  = req_wdata[15:0];
        K_QSEL:  qsel_d  = req_wdata[QSEL_W-1:0];
        K_DFSEL: dfsel_d = req_wdata[31:0];
        K_GFSEL: gfsel_d = req_wdata[31:0];
        K_GFEAT: begin
          if (gfsel_q < 32'd2) begin
            ackv_d = 1'b1;
            ackb_d = gfsel_q[0] ? {req_wdata[31:0], 32'd0} : {32'd0, req_wdata[31:0]};
          end else begin
            err_d = 1'b1;
          end
        end
        K_QSIZE, K_QVEC, K_QEN, K_RING_LO, K_RING_HI, K_RING_Q: ;
        default: bad_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      drv_q   <= '0;
      msix_q  <= '0;
      qsel_q  <= '0;
      dfsel_q <= '0;
      gfsel_q <= '0;
    end else if (wr) begin
      drv_q   <= drv_d;
      msix_q  <= msix_d;
      qsel_q  <= qsel_d;
      dfsel_q <= dfsel_d;
      gfsel_q <= gfsel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rv_q   <= 1'b0;
      rdat_q <= '0;
      ackv_q <= 1'b0;
      ackb_q <= '0;
      err_q  <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      rv_q   <= rv_d;
      rdat_q <= rdat_d;
      ackv_q <= ackv_d;
      ackb_q <= ackb_d;
      err_q  <= err_d;
      bad_q  <= bad_d;
    end
  end

  assign rsp_valid      = rv_q;
  assign rsp_rdata      = rdat_q;
  assign feat_ack_valid = ackv_q;
  assign feat_ack_bits  = ackb_q;
  assign feat_sel_err   = err_q;
  assign bad_access     = bad_q;
  assign drv_status     = drv_q;
endmodule

// File: rtl/vq_cfg_regs_chk.sv
module vq_cfg_regs_chk #(
  parameter int unsigned OFS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [OFS_W-1:0] req_offset,
  input logic [3:0]       req_size,
  input logic [7:0]       cfg_gen,
  input logic             rsp_valid,
  input logic [63:0]      rsp_rdata,
  input logic             feat_ack_valid,
  input logic [63:0]      feat_ack_bits,
  input logic             feat_sel_err,
  input logic             bad_access
);
  logic sz_ok;
  assign sz_ok = (req_size == 4'd1) || (req_size == 4'd2) ||
                 (req_size == 4'd4) || (req_size == 4'd8);

  p_rsp_after_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && sz_ok) |=> rsp_valid);

  p_no_rsp_otherwise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write && sz_ok) |=> !rsp_valid);

  p_gen_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 4'd1 && req_offset == OFS_W'('h15))
      |=> (rsp_rdata == 64'($past(cfg_gen))));

  p_ack_err_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(feat_ack_valid && feat_sel_err));

  p_ack_one_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    feat_ack_valid |-> (feat_ack_bits[63:32] == 32'd0 || feat_ack_bits[31:0] == 32'd0));

  p_qword_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 4'd8) |=> (rsp_rdata == 64'd0));

  p_bad_size_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sz_ok) |=> (!rsp_valid && !bad_access && !feat_ack_valid && !feat_sel_err));

  p_bad_needs_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past(req_valid && req_write));
endmodule

bind vq_cfg_regs vq_cfg_regs_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_offset(req_offset), .req_size(req_size), .cfg_gen(cfg_gen),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .feat_ack_valid(feat_ack_valid),
  .feat_ack_bits(feat_ack_bits), .feat_sel_err(feat_sel_err), .bad_access(bad_access)
);

// File: tb/vq_cfg_regs_test.sv
module vq_cfg_regs_test;
  localparam int unsigned NQ = 3;
  localparam logic [63:0] FEAT = 64'h1234_5678_9ABC_DEF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_offset = '0;
  logic [3:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  cfg_gen = 8'h5A;
  logic rsp_valid, feat_ack_valid, feat_sel_err, bad_access;
  logic [63:0] rsp_rdata, feat_ack_bits;
  logic [7:0]  drv_status;
  logic [NQ-1:0] q_enabled;
  logic [NQ*64-1:0] q_desc_addr, q_avail_addr, q_used_addr;

  int errors = 0;
  int checks = 0;

  // observed after each transaction
  logic o_rv, o_ackv, o_err, o_bad;
  logic [63:0] o_rd, o_ackb;

  always #5 clk = ~clk;

  vq_cfg_regs #(.NUM_QUEUES(NQ), .OFS_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
    .dev_features(FEAT), .cfg_gen(cfg_gen), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .feat_ack_valid(feat_ack_valid),
    .feat_ack_bits(feat_ack_bits), .feat_sel_err(feat_sel_err),
    .bad_access(bad_access), .drv_status(drv_status), .q_enabled(q_enabled),
    .q_desc_addr(q_desc_addr), .q_avail_addr(q_avail_addr), .q_used_addr(q_used_addr)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [7:0] ofs, input logic [3:0] sz,
                      input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_offset = ofs; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    o_rv = rsp_valid; o_rd = rsp_rdata; o_ackv = feat_ack_valid;
    o_ackb = feat_ack_bits; o_err = feat_sel_err; o_bad = bad_access;
  endtask

  task automatic wr(input logic [7:0] ofs, input logic [3:0] sz, input logic [63:0] d);
    xfer(1'b1, ofs, sz, d);
  endtask

  task automatic rd(input logic [7:0] ofs, input logic [3:0] sz);
    xfer(1'b0, ofs, sz, 64'd0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check("R12 drv_status", 64'(drv_status), 0);
    check("R12 q_enabled", 64'(q_enabled), 0);
    check("R12 ring ports", q_desc_addr[63:0] | q_avail_addr[63:0] | q_used_addr[63:0], 0);
    check("R12 strobes", {60'd0, rsp_valid, feat_ack_valid, feat_sel_err, bad_access}, 0);
    rd(8'h16, 4'd2); check("R12 qsel", o_rd, 0);
    rd(8'h10, 4'd2); check("R12 msix", o_rd, 0);

    // R1 response timing
    rd(8'h12, 4'd2); check("R1 rsp_valid on read", 64'(o_rv), 1);
    @(negedge clk); check("R1 rsp_valid one cycle", 64'(rsp_valid), 0);
    wr(8'h10, 4'd2, 64'h1); check("R1 no rsp on write", 64'(o_rv), 0);

    // R2 byte map
    wr(8'h14, 4'd1, 64'hA5); rd(8'h14, 4'd1); check("R2 status rw", o_rd, 64'hA5);
    check("R2 drv_status port", 64'(drv_status), 64'hA5);
    rd(8'h15, 4'd1); check("R2 generation", o_rd, 64'h5A);
    wr(8'h15, 4'd1, 64'h00); rd(8'h15, 4'd1); check("R2 generation write ignored", o_rd, 64'h5A);
    rd(8'h14, 4'd1); check("R2 status kept after 0x15 write", o_rd, 64'hA5);

    // R3 word device registers
    wr(8'h10, 4'd2, 64'hBEEF); rd(8'h10, 4'd2); check("R3 msix rw", o_rd, 64'hBEEF);
    rd(8'h12, 4'd2); check("R3 queue count", o_rd, NQ);
    wr(8'h16, 4'd2, 64'h55AA); rd(8'h16, 4'd2); check("R3 qsel rw", o_rd, 64'h55AA);
    rd(8'h1E, 4'd2); check("R5 notify off far", o_rd, 64'h55AA);

    // R4/R5/R6/R9 per-queue sweep including one past the end
    for (int q = 0; q <= NQ; q++) begin
      wr(8'h16, 4'd2, 64'(q));
      wr(8'h18, 4'd2, 64'(16'h100 + q)); o_bad = o_bad;
      check("R6 no flag on per-queue write", 64'(o_bad), 0);
      wr(8'h1A, 4'd2, 64'(16'h0A00 + q));
      wr(8'h1C, 4'd2, 64'h1);
      wr(8'h20, 4'd4, 64'(32'hD000_0000 + q));
      wr(8'h24, 4'd4, 64'(32'hD100_0000 + q));
      wr(8'h2C, 4'd4, 64'(32'hA100_0000 + q));
      wr(8'h28, 4'd4, 64'(32'hA000_0000 + q));
      wr(8'h30, 4'd4, 64'h1111_1111);
      wr(8'h30, 4'd8, {32'hE100_0000 + 32'(q), 32'hE000_0000 + 32'(q)});
      wr(8'h34, 4'd4, 64'(32'hE200_0000 + q));
      rd(8'h1E, 4'd2); check("R5 notify off", o_rd, 64'(q));
    end
    for (int q = 0; q <= NQ; q++) begin
      logic inr;
      inr = (q < NQ);
      wr(8'h16, 4'd2, 64'(q));
      rd(8'h18, 4'd2); check(inr ? "R4 size" : "R6 size out of range", o_rd, inr ? 64'(16'h100 + q) : 0);
      rd(8'h1A, 4'd2); check(inr ? "R4 vector" : "R6 vector out of range", o_rd, inr ? 64'(16'h0A00 + q) : 0);
      rd(8'h1C, 4'd2); check(inr ? "R4 enable" : "R6 enable out of range", o_rd, inr ? 1 : 0);
      if (inr) begin
        check("R9 desc lo/hi", q_desc_addr[q*64 +: 64], {32'hD100_0000 + 32'(q), 32'hD000_0000 + 32'(q)});
        check("R9 avail hi then lo", q_avail_addr[q*64 +: 64], {32'hA100_0000 + 32'(q), 32'hA000_0000 + 32'(q)});
        check("R9 used qword then hi", q_used_addr[q*64 +: 64], {32'hE200_0000 + 32'(q), 32'hE000_0000 + 32'(q)});
      end
    end
    check("R4 q_enabled port", 64'(q_enabled), 64'((1 << NQ) - 1));

    // R4 enable only on exact 1
    wr(8'h16, 4'd2, 64'd1);
    for (int k = 0; k < 5; k++) begin
      logic [15:0] v;
      case (k)
        0: v = 16'h0000; 1: v = 16'h0001; 2: v = 16'h0002; 3: v = 16'h0003; default: v = 16'h0101;
      endcase
      wr(8'h1C, 4'd2, 64'(v));
      rd(8'h1C, 4'd2); check("R4 enable exact one", o_rd, (v == 16'd1) ? 1 : 0);
      check("R4 q_enabled bit", 64'(q_enabled[1]), (v == 16'd1) ? 1 : 0);
    end

    // R7 device feature pages
    for (int s = 0; s < 4; s++) begin
      wr(8'h00, 4'd4, 64'(s));
      rd(8'h00, 4'd4); check("R7 device select rw", o_rd, 64'(s));
      rd(8'h04, 4'd4);
      check("R7 device feature page", o_rd, (s < 2) ? ((FEAT >> (32 * s)) & 64'hFFFF_FFFF) : 0);
    end

    // R8 driver feature pages
    for (int s = 0; s < 4; s++) begin
      logic [63:0] dv;
      dv = 64'(32'hC0DE_0000 + 32'(s));
      wr(8'h08, 4'd4, 64'(s));
      rd(8'h08, 4'd4); check("R7 driver select rw", o_rd, 64'(s));
      wr(8'h0C, 4'd4, dv);
      check("R8 ack strobe", 64'(o_ackv), (s < 2) ? 1 : 0);
      check("R8 ack bits", o_ackv ? o_ackb : 0, (s < 2) ? (dv << (32 * s)) : 0);
      check("R8 select error", 64'(o_err), (s < 2) ? 0 : 1);
      @(negedge clk); check("R8 strobe single cycle", 64'(feat_ack_valid | feat_sel_err), 0);
    end

    // R10 qword reads and bad sizes
    wr(8'h16, 4'd2, 64'd0);
    rd(8'h20, 4'd8); check("R10 qword read zero", o_rd, 0);
    check("R10 qword read responds", 64'(o_rv), 1);
    rd(8'h14, 4'd3); check("R10 bad size read silent", 64'(o_rv), 0);
    wr(8'h14, 4'd3, 64'h11); check("R10 bad size no flag", 64'(o_bad), 0);
    rd(8'h14, 4'd1); check("R10 bad size no write", o_rd, 64'hA5);
    wr(8'h20, 4'd16, 64'h0); check("R10 bad size ring kept", q_desc_addr[63:0], 64'hD100_0000_D000_0000);

    // R11 unmapped and read-only writes
    rd(8'h40, 4'd4); check("R11 unmapped read", o_rd, 0);
    rd(8'h14, 4'd2); check("R11 status via word unmapped", o_rd, 0);
    wr(8'h12, 4'd2, 64'h9); check("R11 ro count flag", 64'(o_bad), 1);
    @(negedge clk); check("R11 flag single cycle", 64'(bad_access), 0);
    rd(8'h12, 4'd2); check("R11 count kept", o_rd, NQ);
    wr(8'h04, 4'd4, 64'h0); check("R11 ro feature flag", 64'(o_bad), 1);
    wr(8'h1E, 4'd2, 64'h7); check("R11 ro notify flag", 64'(o_bad), 1);
    rd(8'h16, 4'd2); check("R11 qsel kept", o_rd, 0);
    wr(8'h15, 4'd1, 64'h0); check("R11 ro generation flag", 64'(o_bad), 1);
    wr(8'h3C, 4'd4, 64'h0); check("R11 unmapped flag", 64'(o_bad), 1);
    wr(8'h20, 4'd2, 64'hFFFF); check("R11 ring via word flag", 64'(o_bad), 1);
    check("R11 ring via word no effect", q_desc_addr[63:0], 64'hD100_0000_D000_0000);
    wr(8'h14, 4'd1, 64'h3C); check("R11 valid write no flag", 64'(o_bad), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule